// File: doc/BRIEF.md
# Parallel Parking Sequencer

This block is the manoeuvre controller for a small four-wheel vehicle that has no steering linkage. It reads three qualified distance values (side-front, side-rear, back) and four coarse zone codes (front, side-front, side-rear, back) from an upstream sensor pipeline. It walks through the steps a driver takes to reverse into a gap beside a row of parked cars. For each step it issues a left-side and a right-side wheel speed, so the vehicle turns by running one side faster than the other.

The outputs are four registered duty commands, one for each wheel, plus a direction bit for a downstream PWM stage. A 4-bit state code drives status LEDs. After reset the block waits through a settling interval with the wheels stopped. It then advances through eleven state codes in a fixed order and never skips a step. A parked state is reached at the end and only reset leaves it. Dwell timers qualify the slow decisions. A tolerance window on the side comparison keeps sensor noise from stalling the alignment steps.

Top module: `park_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, state_led is 0, every duty output is 0 and reverse is 0. State codes are: settle 0, approach 1, level-up 2, search 3, gap 4, back-off 5, swing-in 6, tuck-in 7, align 8, creep 9, parked 10.
- R2: The settle state lasts exactly SETTLE_CYCLES clock edges after reset with all duties 0, then the code becomes 1.
- R3: Zone codes are 0 close, 1 medium, 2 far, 3 error. In approach, the left wheels run at 6 and the right at 4, forward. The block moves to level-up on the edge where the side-front zone is close.
- R4: In level-up, left runs at 3 and right at 6, forward. The block advances to search only when the two side readings differ by at most SIDE_TOL (4). A difference of 5 holds the state.
- R5: In search, both sides run at 5, forward. A single far side zone does not advance the state. Both side zones far moves it to gap.
- R6: In gap, both sides run at 5, forward. Both side zones close moves it to back-off.
- R7: In back-off, both sides run at 5 with reverse=1. It leaves for swing-in only after the back zone has been far on HOLD_CYCLES consecutive edges. Any break in that run restarts the count.
- R8: On leaving back-off, the side-front reading is latched as a reference. In swing-in, left runs at 7 and right at 3, reverse. The block moves to tuck-in when the side-front reading differs from the reference by more than TURN_DELTA (16).
- R9: In tuck-in, with reverse set, the right side runs at 8 and the left at 7 - floor(back_reading*6/256). The block moves to align when the back zone is close.
- R10: Align alternates every WIGGLE_CYCLES edges between forward left 4 / right 2 (the first phase) and reverse left 2 / right 4. It enters creep once the side readings are within SIDE_TOL.
- R11: In creep, both sides run at 4, forward. Front zone close enters parked. Parked holds all duties at 0 and keeps code 10 whatever the inputs.
- R12: While any zone input carries the error code, the duties and reverse are 0 from the next edge on, and the state does not advance. Normal behaviour resumes once the error clears.
- R13: No duty output ever exceeds 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_side_f | input | 8 | Side-front reading, larger means closer |
| rd_side_r | input | 8 | Side-rear reading |
| rd_back | input | 8 | Back reading |
| zn_front | input | 2 | Front zone code |
| zn_side_f | input | 2 | Side-front zone code |
| zn_side_r | input | 2 | Side-rear zone code |
| zn_back | input | 2 | Back zone code |
| duty_fl | output | 4 | Front-left duty, tenths |
| duty_fr | output | 4 | Front-right duty |
| duty_rl | output | 4 | Rear-left duty |
| duty_rr | output | 4 | Rear-right duty |
| reverse | output | 1 | 1 when the wheels drive backwards |
| state_led | output | 4 | Current state code |

## Verification
The bench steps the side difference across the tolerance edge, from 5 to 4, and the turn offset across its threshold, from 16 to 17. A design with an off-by-one compare would leave or stay one step early. The back-off run is broken one cycle short of completion. A timer that failed to restart would move into swing-in too soon. An error code is raised exactly when the search exit condition becomes true, which would expose a design that lets error only mute the wheels while the state still advances. The parked state is then hit with far and close zones to show that nothing moves it or the wheels.

// File: rtl/park_pkg.sv
package park_pkg;
  localparam int DUTY_W   = 4;
  localparam int DUTY_MAX = 10;
  localparam int RD_W     = 8;

  typedef enum logic [1:0] {
    Z_CLOSE = 2'd0,
    Z_MED   = 2'd1,
    Z_FAR   = 2'd2,
    Z_ERR   = 2'd3
  } zone_t;

  typedef enum logic [3:0] {
    S_SETTLE = 4'd0,
    S_APPR   = 4'd1,
    S_LEVEL  = 4'd2,
    S_SEARCH = 4'd3,
    S_GAP    = 4'd4,
    S_BACK   = 4'd5,
    S_SWING  = 4'd6,
    S_TUCK   = 4'd7,
    S_ALIGN  = 4'd8,
    S_CREEP  = 4'd9,
    S_PARKED = 4'd10
  } pstate_t;

  typedef struct packed {
    logic [DUTY_W-1:0] left;
    logic [DUTY_W-1:0] right;
    logic              rev;
  } wheel_cmd_t;
endpackage

// File: rtl/park_dwell_timer.sv
module park_dwell_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || !run) count_q <= '0;
    else if (count_q == LAST) count_q <= '0;
    else count_q <= count_q + 1'b1;
  end

  assign done = run && (count_q == LAST);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST); // R7

  AST_TMR_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run |=> count_q == '0); // R7
endmodule

// File: rtl/park_side_match.sv
module park_side_match #(
  parameter int W   = 8,
  parameter int TOL = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         near
);
  logic [W-1:0] diff;
  always_comb begin
    diff = (a >= b) ? (a - b) : (b - a);
    near = (diff <= W'(TOL));
  end
endmodule

// File: rtl/park_wheel_policy.sv
module park_wheel_policy
  import park_pkg::*;
(
  input  pstate_t            state,
  input  logic               phase,
  input  logic [RD_W-1:0]    back_rd,
  output wheel_cmd_t         cmd
);
  logic [RD_W+2:0] scaled;
  logic [2:0]      slow;

  always_comb begin
    scaled = {3'b000, back_rd} * (RD_W+3)'(6);
    slow   = scaled[RD_W+2:RD_W];
    cmd    = '0;
    unique case (state)
      S_APPR:   begin cmd.left = 4'd6; cmd.right = 4'd4; end
      S_LEVEL:  begin cmd.left = 4'd3; cmd.right = 4'd6; end
      S_SEARCH,
      S_GAP:    begin cmd.left = 4'd5; cmd.right = 4'd5; end
      S_BACK:   begin cmd.left = 4'd5; cmd.right = 4'd5; cmd.rev = 1'b1; end
      S_SWING:  begin cmd.left = 4'd7; cmd.right = 4'd3; cmd.rev = 1'b1; end
      S_TUCK:   begin
        cmd.left  = 4'd7 - {1'b0, slow};
        cmd.right = 4'd8;
        cmd.rev   = 1'b1;
      end
      S_ALIGN:  begin
        if (phase) begin cmd.left = 4'd2; cmd.right = 4'd4; cmd.rev = 1'b1; end
        else       begin cmd.left = 4'd4; cmd.right = 4'd2; end
      end
      S_CREEP:  begin cmd.left = 4'd4; cmd.right = 4'd4; end
      default:  cmd = '0;
    endcase
  end
endmodule

// File: rtl/park_seq.sv
module park_seq
  import park_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50_000_000,
  parameter int HOLD_CYCLES   = 5_000_000,
  parameter int WIGGLE_CYCLES = 2_500_000,
  parameter int SIDE_TOL      = 4,
  parameter int TURN_DELTA    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  rd_side_f,
  input  logic [7:0]  rd_side_r,
  input  logic [7:0]  rd_back,
  input  logic [1:0]  zn_front,
  input  logic [1:0]  zn_side_f,
  input  logic [1:0]  zn_side_r,
  input  logic [1:0]  zn_back,
  output logic [3:0]  duty_fl,
  output logic [3:0]  duty_fr,
  output logic [3:0]  duty_rl,
  output logic [3:0]  duty_rr,
  output logic        reverse,
  output logic [3:0]  state_led
);
  pstate_t         state_q, state_d;
  logic [RD_W-1:0] ref_q;
  logic            phase_q;
  logic            err, sides_near, settle_done, hold_done, wig_done, swung;
  logic [RD_W-1:0] turn_diff;
  wheel_cmd_t      cmd;

  assign err = (zn_front == Z_ERR) || (zn_side_f == Z_ERR) ||
               (zn_side_r == Z_ERR) || (zn_back == Z_ERR);

  park_dwell_timer #(.LIMIT(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst(rst), .run(state_q == S_SETTLE), .done(settle_done));

  park_dwell_timer #(.LIMIT(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst(rst),
    .run((state_q == S_BACK) && (zn_back == Z_FAR)), .done(hold_done));

  park_dwell_timer #(.LIMIT(WIGGLE_CYCLES)) u_wiggle (
    .clk(clk), .rst(rst),
    .run((state_q == S_ALIGN) && !err), .done(wig_done));

  park_side_match #(.W(RD_W), .TOL(SIDE_TOL)) u_match (
    .a(rd_side_f), .b(rd_side_r), .near(sides_near));

  assign turn_diff = (rd_side_f >= ref_q) ? (rd_side_f - ref_q) : (ref_q - rd_side_f);
  assign swung     = turn_diff > RD_W'(TURN_DELTA);

  always_comb begin
    state_d = state_q;
    if (!err) begin
      unique case (state_q)
        S_SETTLE: if (settle_done) state_d = S_APPR;
        S_APPR:   if (zn_side_f == Z_CLOSE) state_d = S_LEVEL;
        S_LEVEL:  if (sides_near) state_d = S_SEARCH;
        S_SEARCH: if (zn_side_f == Z_FAR && zn_side_r == Z_FAR) state_d = S_GAP;
        S_GAP:    if (zn_side_f == Z_CLOSE && zn_side_r == Z_CLOSE) state_d = S_BACK;
        S_BACK:   if (hold_done) state_d = S_SWING;
        S_SWING:  if (swung) state_d = S_TUCK;
        S_TUCK:   if (zn_back == Z_CLOSE) state_d = S_ALIGN;
        S_ALIGN:  if (sides_near) state_d = S_CREEP;
        S_CREEP:  if (zn_front == Z_CLOSE) state_d = S_PARKED;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_SETTLE;
      ref_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_BACK && state_d == S_SWING) ref_q <= rd_side_f;
      if (state_q != S_ALIGN) phase_q <= 1'b0;
      else if (wig_done) phase_q <= ~phase_q;
    end
  end

  park_wheel_policy u_policy (
    .state(state_q), .phase(phase_q), .back_rd(rd_back), .cmd(cmd));

  always_ff @(posedge clk) begin
    if (rst || err) begin
      duty_fl <= '0; duty_rl <= '0;
      duty_fr <= '0; duty_rr <= '0;
      reverse <= 1'b0;
    end else begin
      duty_fl <= cmd.left;  duty_rl <= cmd.left;
      duty_fr <= cmd.right; duty_rr <= cmd.right;
      reverse <= cmd.rev;
    end
  end

  assign state_led = state_q;

  AST_DUTY_CEIL: assert property (@(posedge clk) disable iff (rst)
    duty_fl <= 4'(DUTY_MAX) && duty_fr <= 4'(DUTY_MAX) &&
    duty_rl <= 4'(DUTY_MAX) && duty_rr <= 4'(DUTY_MAX)); // R13

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
    err |=> (duty_fl == 0 && duty_fr == 0 && duty_rl == 0 && duty_rr == 0 && !reverse)); // R12

  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (rst)
    err |=> $stable(state_q)); // R12

  AST_PARKED_STICKY: assert property (@(posedge clk) disable iff (rst)
    state_q == S_PARKED |=> state_q == S_PARKED); // R11

  AST_SETTLE_STILL: assert property (@(posedge clk) disable iff (rst)
    state_q == S_SETTLE |=> (duty_fl == 0 && duty_fr == 0 && !reverse)); // R2

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    state_q != S_PARKED |=> ($stable(state_q) ||
      4'(state_q) == 4'($past(state_q)) + 4'd1)); // R1

  AST_BACK_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BACK && zn_back != Z_FAR) |=> state_q == S_BACK); // R7
endmodule

// File: tb/park_seq_tb.sv
module park_seq_tb_top;
  localparam int SETTLE = 20;
  localparam int HOLD   = 8;
  localparam int WIG    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rd_side_f = 8'h50, rd_side_r = 8'h50, rd_back = 8'h50;
  logic [1:0] zn_front = 2'd1, zn_side_f = 2'd1, zn_side_r = 2'd1, zn_back = 2'd1;
  logic [3:0] duty_fl, duty_fr, duty_rl, duty_rr, state_led;
  logic       reverse;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  park_seq #(.SETTLE_CYCLES(SETTLE), .HOLD_CYCLES(HOLD), .WIGGLE_CYCLES(WIG),
             .SIDE_TOL(4), .TURN_DELTA(16)) dut_i (
    .clk(clk), .rst(rst),
    .rd_side_f(rd_side_f), .rd_side_r(rd_side_r), .rd_back(rd_back),
    .zn_front(zn_front), .zn_side_f(zn_side_f), .zn_side_r(zn_side_r), .zn_back(zn_back),
    .duty_fl(duty_fl), .duty_fr(duty_fr), .duty_rl(duty_rl), .duty_rr(duty_rr),
    .reverse(reverse), .state_led(state_led));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_cmd(input string tag, input int l, input int r, input int rv);
    check({tag, " fl"}, duty_fl, l);
    check({tag, " rl"}, duty_rl, l);
    check({tag, " fr"}, duty_fr, r);
    check({tag, " rr"}, duty_rr, r);
    check({tag, " rev"}, reverse, rv);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3);
    check("R1 state in reset", state_led, 0);
    check_cmd("R1 reset", 0, 0, 0);
    rst = 1'b0;
    step(1);
    check("R1 first cycle", state_led, 0);
    check_cmd("R1 first cycle", 0, 0, 0);
  endtask

  task automatic t_settle();
    step(SETTLE - 2);
    check("R2 still settling", state_led, 0);
    check_cmd("R2 settle", 0, 0, 0);
    step(1);
    check("R2 settle done", state_led, 1);
  endtask

  task automatic t_approach();
    step(2);
    check_cmd("R3 approach", 6, 4, 0);
    zn_side_f = 2'd0;
    step(1);
    check("R3 to level-up", state_led, 2);
  endtask

  task automatic t_level();
    zn_side_f = 2'd1;
    rd_side_f = 8'h50; rd_side_r = 8'h55;
    step(3);
    check("R4 diff 5 holds", state_led, 2);
    check_cmd("R4 level-up", 3, 6, 0);
    rd_side_r = 8'h54;
    step(1);
    check("R4 diff 4 advances", state_led, 3);
  endtask

  task automatic t_search();
    step(2);
    check_cmd("R5 search", 5, 5, 0);
    zn_side_f = 2'd2;
    step(3);
    check("R5 one side far holds", state_led, 3);
    zn_side_r = 2'd2; zn_front = 2'd3;
    step(3);
    check("R12 error freezes", state_led, 3);
    check_cmd("R12 error stops", 0, 0, 0);
    zn_front = 2'd1;
    step(1);
    check("R12 resume to gap", state_led, 4);
  endtask

  task automatic t_gap();
    step(2);
    check_cmd("R6 gap", 5, 5, 0);
    zn_side_f = 2'd0; zn_side_r = 2'd0;
    step(1);
    check("R6 to back-off", state_led, 5);
  endtask

  task automatic t_back();
    step(2);
    check_cmd("R7 back-off", 5, 5, 1);
    rd_side_f = 8'h60;
    zn_back = 2'd2;
    step(HOLD - 2);
    zn_back = 2'd1;
    step(1);
    zn_back = 2'd2;
    step(HOLD - 1);
    check("R7 broken run restarts", state_led, 5);
    step(1);
    check("R7 to swing-in", state_led, 6);
  endtask

  task automatic t_swing();
    step(2);
    check_cmd("R8 swing-in", 7, 3, 1);
    rd_side_f = 8'h70;
    step(3);
    check("R8 offset 16 holds", state_led, 6);
    rd_side_f = 8'h71;
    step(1);
    check("R8 offset 17 advances", state_led, 7);
  endtask

  task automatic t_tuck();
    rd_back = 8'hC0;
    step(2);
    check_cmd("R9 tuck close", 3, 8, 1);
    rd_back = 8'h40;
    step(1);
    check_cmd("R9 tuck far", 6, 8, 1);
    zn_back = 2'd0;
    step(1);
    check("R9 to align", state_led, 8);
  endtask

  task automatic t_align();
    step(1);
    check_cmd("R10 align phase a", 4, 2, 0);
    step(WIG - 1);
    check_cmd("R10 align phase a end", 4, 2, 0);
    step(1);
    check_cmd("R10 align phase b", 2, 4, 1);
    check("R10 mismatch holds", state_led, 8);
    rd_side_r = 8'h6E;
    step(1);
    check("R10 to creep", state_led, 9);
  endtask

  task automatic t_creep_park();
    step(2);
    check_cmd("R11 creep", 4, 4, 0);
    zn_front = 2'd0;
    step(1);
    check("R11 parked", state_led, 10);
    step(1);
    check_cmd("R11 parked stop", 0, 0, 0);
    zn_front = 2'd2; zn_side_f = 2'd2; zn_side_r = 2'd2; zn_back = 2'd2;
    rd_side_f = 8'h00; rd_side_r = 8'hFF;
    step(5);
    check("R11 parked sticky", state_led, 10);
    check_cmd("R11 parked sticky", 0, 0, 0);
    check("R13 duty ceiling", (duty_fl <= 10) ? 1 : 0, 1);
  endtask

  initial begin
    t_reset();
    t_settle();
    t_approach();
    t_level();
    t_search();
    t_gap();
    t_back();
    t_swing();
    t_tuck();
    t_align();
    t_creep_park();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule